// File: doc/BRIEF.md
# Bitmap-Based Memory Write Monitor

This block sits beside a memory controller and watches the write traffic passing through it, one word at a time. Privileged security software keeps a protection bitmap in ordinary system memory, one bit for each 4-byte word of a monitored window. For every write that falls inside the window, the block works out which bitmap word and bit cover the target address. It reads that bitmap word through a read-only master port and raises an interrupt if the bit is set. The write itself is never blocked or slowed down. Detection is reported after the write has happened.

Captured writes wait in a small queue until they are resolved. The last bitmap word fetched is held in a one-entry cache, so that writes to neighbouring words need no new fetch. The first offending write has its address and data latched for the handler. The interrupt stays high until software pulses a clear input. Lost events, which happen when the queue is full, raise a sticky overflow flag. A global enable gates the whole block.

Top module: `bitmap_write_monitor`

## Requirements
- R1: A snooped transaction with `snp_we` low (a read) is never captured: it causes no bitmap fetch and no interrupt, even inside the window on a protected word.
- R2: For an address A in the window, the bit index is i = (A - mon_base) >> 2. The fetch goes to `rd_addr` = bmp_base + ((i >> 5) << 2), a word-aligned address, and the deciding bit is `rd_data[i[4:0]]`.
- R3: A write outside [mon_base, mon_base + mon_size) is dropped without any fetch and raises no interrupt.
- R4: A captured write whose bitmap bit is 1 raises `irq`. It also latches the write's address into `hit_addr` and its data into `hit_data`.
- R5: A captured write whose bitmap bit is 0 leaves `irq`, `hit_addr` and `hit_data` unchanged.
- R6: Once a hit is pending, `irq` stays high and `hit_addr`/`hit_data` keep the first hit's values. Later hits only set `multi_hit`. A one-cycle `clr` pulse drops the pending hit, `multi_hit` and `overflow`.
- R7: The queue holds 8 writes. A captured in-window write that finds it full is lost, sets the sticky `overflow` flag and raises `irq`.
- R8: A write whose bitmap word equals the cached word is decided without a new fetch.
- R9: A snooped write into the bitmap region (bmp_base up to the bitmap's size, which is ceil(mon_size/128) words) invalidates the cache. The next lookup fetches again and uses the new bit.
- R10: While `enable` is low, no write is captured, no fetch is issued, and the queued writes are discarded. A fetch already in flight is completed and its result is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global monitor enable |
| mon_base | input | AW | Start of the monitored window (byte address) |
| mon_size | input | AW | Size of the monitored window in bytes |
| bmp_base | input | AW | Byte address of bitmap word 0 |
| snp_valid | input | 1 | Snooped transaction present this cycle |
| snp_we | input | 1 | Snooped transaction is a write |
| snp_addr | input | AW | Snooped byte address |
| snp_data | input | DW | Snooped write data |
| rd_req | output | 1 | One-cycle bitmap read request |
| rd_addr | output | AW | Bitmap word address of the request |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Bitmap word returned |
| clr | input | 1 | Clear pending hit, multi-hit and overflow |
| irq | output | 1 | Interrupt level (hit pending or overflow) |
| hit_addr | output | AW | Address of first offending write |
| hit_data | output | DW | Data of first offending write |
| multi_hit | output | 1 | More hits arrived while one was pending |
| overflow | output | 1 | Sticky: a captured write was lost |

## Verification
The random phase mixes several kinds of traffic. It sends reads on protected words and writes outside the window, and these must leave the status alone. It rewrites bitmap words through the snooped bus, which shows whether cache invalidation picks up the new bits. It also sends watched writes on a bitmap that is about half set, which separates correct bit selection from off-by-one indexing. Directed cases check the exact fetch address, one fetch for two writes in the same bitmap word, a ninth write into a stalled queue, and a disable while entries are queued with a fetch in flight.

// File: rtl/bitmap_write_monitor.sv
module bitmap_write_monitor #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [AW-1:0] mon_base,
  input  logic [AW-1:0] mon_size,
  input  logic [AW-1:0] bmp_base,
  input  logic          snp_valid,
  input  logic          snp_we,
  input  logic [AW-1:0] snp_addr,
  input  logic [DW-1:0] snp_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [31:0]   rd_data,
  input  logic          clr,
  output logic          irq,
  output logic [AW-1:0] hit_addr,
  output logic [DW-1:0] hit_data,
  output logic          multi_hit,
  output logic          overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  logic          busy, drop, taint, pending;
  logic          c_vld;
  logic [AW-1:0] c_tag;
  logic [31:0]   c_word;

  wire cap    = enable && snp_valid && snp_we;
  wire [AW-1:0] woff = snp_addr - mon_base;
  wire in_win = (snp_addr >= mon_base) && (woff < mon_size);
  wire [AW-1:0] bmp_bytes = ((mon_size + AW'(127)) >> 7) << 2;
  wire [AW-1:0] boff = snp_addr - bmp_base;
  wire in_bmp = (snp_addr >= bmp_base) && (boff < bmp_bytes);
  wire inv    = cap && in_bmp;
  wire full   = (cnt == (PW+1)'(DEPTH));
  wire push   = cap && in_win && !full;
  wire lost   = cap && in_win && full;

  wire [AW-1:0] idx   = (q_addr[rp] - mon_base) >> 2;
  wire [AW-1:0] waddr = bmp_base + ((idx >> 5) << 2);
  wire [4:0]    bpos  = idx[4:0];
  wire          nonempty = (cnt != '0);
  wire          c_hit = c_vld && (c_tag == waddr);

  wire hit_now = enable && !busy && nonempty && c_hit;
  wire miss    = enable && !busy && nonempty && !c_hit;
  wire resolve = busy && rd_valid && enable && !drop && nonempty;
  wire pop     = hit_now || resolve;
  wire bit_set = hit_now ? c_word[bpos] : rd_data[bpos];
  wire flag    = pop && bit_set;

  assign irq = pending || overflow;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= snp_addr;
      q_data[wp] <= snp_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (!enable) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; drop <= 1'b0; taint <= 1'b0;
      rd_req <= 1'b0; rd_addr <= '0;
      c_vld <= 1'b0; c_tag <= '0; c_word <= '0;
    end else begin
      rd_req <= miss;
      if (miss) begin
        busy <= 1'b1; drop <= 1'b0; taint <= 1'b0;
        rd_addr <= waddr;
      end else if (busy && rd_valid) begin
        busy <= 1'b0;
      end
      if (busy && !enable) drop <= 1'b1;
      if (busy && inv) taint <= 1'b1;
      if (resolve && !taint && !inv) begin
        c_vld <= 1'b1; c_tag <= rd_addr; c_word <= rd_data;
      end else if (inv || !enable) begin
        c_vld <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0; multi_hit <= 1'b0; overflow <= 1'b0;
      hit_addr <= '0; hit_data <= '0;
    end else begin
      if (clr) begin
        pending <= 1'b0; multi_hit <= 1'b0; overflow <= 1'b0;
      end
      if (flag) begin
        if (pending && !clr) multi_hit <= 1'b1;
        else begin
          pending <= 1'b1;
          hit_addr <= q_addr[rp];
          hit_data <= q_data[rp];
        end
      end
      if (lost) overflow <= 1'b1;
    end
  end
endmodule

module bitmap_write_monitor_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] bmp_base,
  input logic          clr,
  input logic          irq,
  input logic          pending,
  input logic          overflow,
  input logic          multi_hit,
  input logic [AW-1:0] hit_addr,
  input logic [DW-1:0] hit_data
);
  // R10
  no_fetch_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !$past(enable)) |-> !rd_req);
  // R2
  fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[1:0] == 2'b00 && rd_addr >= bmp_base));
  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);
  // R6
  hit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> ($stable(hit_addr) && $stable(hit_data) && irq));
  // R6
  multi_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(multi_hit) |-> irq);
  // R6
  clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !multi_hit);
endmodule

bind bitmap_write_monitor bitmap_write_monitor_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rd_req(rd_req), .rd_addr(rd_addr),
  .bmp_base(bmp_base), .clr(clr), .irq(irq), .pending(pending),
  .overflow(overflow), .multi_hit(multi_hit), .hit_addr(hit_addr), .hit_data(hit_data)
);

// File: tb/tb_bitmap_write_monitor.sv
`timescale 1ns/1ps
module tb_bitmap_write_monitor;
  localparam logic [31:0] MB = 32'h1000_0000;
  localparam logic [31:0] MS = 32'h0000_1000;
  localparam logic [31:0] BB = 32'h2000_0000;

  logic clk = 0, rst_n = 0, enable = 0;
  logic snp_valid = 0, snp_we = 0, clr = 0;
  logic [31:0] snp_addr = 0, snp_data = 0;
  logic rd_req, rd_valid = 0;
  logic [31:0] rd_addr, rd_data = 0;
  logic irq, multi_hit, overflow;
  logic [31:0] hit_addr, hit_data;
  logic [31:0] mon_base = MB, mon_size = MS, bmp_base = BB;

  always #5 clk = ~clk;

  bitmap_write_monitor dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mon_base(mon_base),
    .mon_size(mon_size), .bmp_base(bmp_base), .snp_valid(snp_valid),
    .snp_we(snp_we), .snp_addr(snp_addr), .snp_data(snp_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .clr(clr), .irq(irq), .hit_addr(hit_addr), .hit_data(hit_data),
    .multi_hit(multi_hit), .overflow(overflow)
  );

  logic [31:0] bm [32];
  int checks = 0, fails = 0, fetches = 0;
  logic stall = 0;
  logic [31:0] last_rd_addr = 0;
  int outstanding = 0, cdown = 0;

  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      fetches++;
      last_rd_addr = rd_addr;
      outstanding = 1;
      cdown = 3;
    end else if (outstanding != 0) begin
      if (cdown > 0) cdown--;
      else if (!stall) begin
        rd_valid <= 1'b1;
        rd_data  <= bm[(last_rd_addr - BB) >> 2];
        outstanding = 0;
      end
    end
  end

  logic exp_pend = 0, exp_multi = 0;
  logic [31:0] exp_addr = 0, exp_data = 0;

  function automatic logic bit_of(input logic [31:0] a);
    logic [31:0] i;
    i = (a - MB) >> 2;
    return bm[i >> 5][i[4:0]];
  endfunction

  function automatic logic [31:0] bmp_word_of(input logic [31:0] a);
    logic [31:0] i;
    i = (a - MB) >> 2;
    return BB + ((i >> 5) << 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic snoop(input logic we, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    snp_valid = 1; snp_we = we; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 0; snp_we = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    exp_pend = 0; exp_multi = 0;
  endtask

  task automatic watched(input logic [31:0] a, input logic [31:0] d);
    snoop(1'b1, a, d);
    if (bit_of(a)) begin
      if (exp_pend) exp_multi = 1;
      else begin exp_pend = 1; exp_addr = a; exp_data = d; end
    end
    settle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int f0;
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < 32; k++) bm[k] = 0;
    repeat (3) @(negedge clk);
    check("R4 reset irq", {31'b0, irq}, 0);
    check("R7 reset overflow", {31'b0, overflow}, 0);
    check("R2 reset rd_req", {31'b0, rd_req}, 0);
    rst_n = 1; enable = 1;
    repeat (2) @(negedge clk);

    // R2 addressing: index 297 -> word 9, bit 9
    bm[9] = 32'h0000_0200;
    f0 = fetches;
    watched(MB + 32'h4A4, 32'hDEAD_0001);
    check("R2 fetch address", last_rd_addr, BB + 32'h24);
    check("R4 irq on set bit", {31'b0, irq}, 1);
    check("R4 hit_addr", hit_addr, MB + 32'h4A4);
    check("R4 hit_data", hit_data, 32'hDEAD_0001);
    // R8 same bitmap word: no new fetch; bit 10 clear
    f0 = fetches;
    watched(MB + 32'h4A8, 32'h1111_2222);
    check("R8 cached no fetch", fetches - f0, 0);
    check("R5 hit_addr kept", hit_addr, MB + 32'h4A4);
    // R6 second hit sets multi
    watched(MB + 32'h4A4, 32'h3333_4444);
    check("R6 multi_hit", {31'b0, multi_hit}, 1);
    check("R6 first data kept", hit_data, 32'hDEAD_0001);
    pulse_clr();
    check("R6 clr drops irq", {31'b0, irq}, 0);
    check("R6 clr drops multi", {31'b0, multi_hit}, 0);
    // R9 bitmap rewrite invalidates cache
    bm[9] = 32'h0000_0400;
    snoop(1'b1, BB + 32'h24, 32'h0000_0400);
    f0 = fetches;
    watched(MB + 32'h4A8, 32'h5555_6666);
    check("R9 refetch after invalidate", fetches - f0, 1);
    check("R9 new bit used", {31'b0, irq}, 1);
    pulse_clr();
    // R1 read of protected word
    f0 = fetches;
    snoop(1'b0, MB + 32'h4A8, 0); settle();
    check("R1 read ignored irq", {31'b0, irq}, 0);
    check("R1 read no fetch", fetches - f0, 0);
    // R3 outside window
    bm[0] = 32'hFFFF_FFFF;
    snoop(1'b1, MB - 4, 1); snoop(1'b1, MB + MS, 2); settle();
    check("R3 outside no fetch", fetches - f0, 0);
    check("R3 outside no irq", {31'b0, irq}, 0);
    // R7 overflow with stalled memory
    bm[20] = 0;
    stall = 1;
    for (int k = 0; k < 9; k++) snoop(1'b1, MB + 32'h0A00 + 4*k, k);
    @(negedge clk);
    check("R7 overflow set", {31'b0, overflow}, 1);
    check("R7 overflow irq", {31'b0, irq}, 1);
    stall = 0;
    repeat (80) @(negedge clk);
    check("R7 overflow sticky", {31'b0, overflow}, 1);
    pulse_clr();
    check("R7 cleared", {31'b0, irq}, 0);
    // R10 disable flushes queue and in-flight fetch
    stall = 1;
    for (int k = 0; k < 3; k++) snoop(1'b1, MB + 4*k, 32'hA0 + k);
    @(negedge clk); enable = 0;
    @(negedge clk); stall = 0;
    settle();
    f0 = fetches;
    snoop(1'b1, MB + 4, 7); settle();
    check("R10 no fetch disabled", fetches - f0, 0);
    enable = 1; settle();
    check("R10 flushed no irq", {31'b0, irq}, 0);

    // random phase
    pulse_clr();
    for (int k = 0; k < 32; k++) bm[k] = $urandom;
    for (int k = 0; k < 32; k++) snoop(1'b1, BB + 4*k, bm[k]);
    settle();
    for (int v = 0; v < 300; v++) begin
      int r;
      logic [31:0] a, d;
      r = $urandom % 8;
      a = MB + (($urandom % (MS >> 2)) << 2);
      d = $urandom;
      if ($urandom % 4 == 0) pulse_clr();
      case (r)
        0: begin snoop(1'b0, a, d); settle(); end
        1: begin snoop(1'b1, MB + MS + (($urandom % 64) << 2), d); settle(); end
        2: begin
          int w;
          w = $urandom % 32;
          bm[w] = d;
          snoop(1'b1, BB + 4*w, d); settle();
        end
        default: watched(a, d);
      endcase
      check("R4/R5/R9 irq", {31'b0, irq}, {31'b0, exp_pend});
      check("R6 multi", {31'b0, multi_hit}, {31'b0, exp_multi});
      if (exp_pend) begin
        check("R4 hit_addr", hit_addr, exp_addr);
        check("R4 hit_data", hit_data, exp_data);
      end
    end
    finish_run();
  end
endmodule